// File: doc/BRIEF.md
# Receive Packet Ring Manager

This block stores received frames in a circular buffer held in a packet RAM organised as 256-byte pages. Two host-set page numbers mark the first page of the ring and the page just past its end. Frames arrive one byte per beat on a valid/ready stream. The block writes the frame body into RAM, starting four bytes into the page named by its current-page pointer, and crosses page boundaries as needed, wrapping from the last ring page back to the first. Once the last byte has been taken, it fills the four reserved bytes at the start of the frame's first page with a header: status, next-page pointer, and the length as low byte then high byte. It then moves the current-page pointer to the page that follows the frame and pulses a packet-received event.

The host owns a boundary pointer that names the page it has most recently released. The hardware never writes into that page. A frame that would need it is dropped: the rest of its bytes are still accepted, but nothing more is written, and a sticky overwrite-warning flag is set. A frame that the MAC side marks as errored on its last beat is also dropped. In both cases the current-page pointer stays where it was, so the partly written space is reused by the next frame. A ring-init pulse loads the pointers from the page bounds. Until that first pulse, the stream is held off.

Stream rules: a byte is transferred on a rising clock edge where both `rx_valid` and `rx_ready` are high. The source must hold its data and flags stable while `rx_ready` is low. `rx_ready` is low before the first ring-init pulse and for the four header-writing cycles after each committed frame.

Top module: `rxring_mgr`

## Requirements
- R1: After reset and before the first `ring_init` pulse, `rx_ready` is low and no RAM write occurs. A `ring_init` pulse sets the current page to `pg_start`, sets the boundary to `pg_stop`-1, clears the overwrite flag and arms the stream.
- R2: A byte is accepted on a clock edge with `rx_valid` and `rx_ready` both high. Body byte k (counting from 0) of a frame is written to byte offset 4+k of the current page, one write per accepted byte. The address is `{page, offset}`, with the page in bits 15:8. The write appears on the cycle after acceptance.
- R3: After a body byte is written at offset 255, writing continues at offset 0 of the next page. The page after `pg_stop`-1 is `pg_start`.
- R4: After the last byte of a committed frame, four header bytes are written at offsets 0, 1, 2, 3 of the frame's first page, on four consecutive cycles. `rx_ready` is low during those cycles.
- R5: Header offset 2 holds the low byte and offset 3 the high byte of the frame length. The length is the number of bytes accepted for the frame, including the trailing 4-byte CRC that the stream carries.
- R6: Header offset 0 is the status byte. Bit 0 is set (intact reception). Bit 5 equals `rx_bcast` as sampled with the last byte. All other bits are 0.
- R7: Header offset 1 holds the page that follows the frame's last body page. The current page takes that value after the fourth header write, and `pkt_rcvd` pulses for exactly that one cycle.
- R8: A frame whose last byte arrives with `rx_err` high gets no header. The current page is unchanged and `pkt_rcvd` does not pulse.
- R9: A `bnd_we` pulse loads `bnd_wdata` into the boundary pointer, which is visible on `bnd_page`.
- R10: If a body byte at offset 255 is not the last byte and the next page equals the boundary, the overwrite flag is set. The remaining bytes of the frame are accepted without any RAM write, and the current page is unchanged. No write ever targets the boundary page.
- R11: If the page after a frame's last body page equals the boundary, the overwrite flag is set. No header is written, and the current page and `pkt_rcvd` stay unchanged.
- R12: The overwrite flag stays set until an `ovw_clr` pulse or `ring_init`.
- R13: Once armed, the current page always lies in [`pg_start`, `pg_stop`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_init | input | 1 | Load ring pointers from the bounds and arm the stream |
| pg_start | input | 8 | First page of the ring |
| pg_stop | input | 8 | Page just past the ring |
| bnd_we | input | 1 | Boundary pointer write strobe |
| bnd_wdata | input | 8 | New boundary page |
| ovw_clr | input | 1 | Clears the overwrite flag |
| rx_valid | input | 1 | Stream byte valid |
| rx_ready | output | 1 | Stream byte accepted when high with valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_err | input | 1 | With the last byte: frame received in error |
| rx_bcast | input | 1 | With the last byte: group destination address |
| mem_we | output | 1 | Packet RAM write strobe |
| mem_addr | output | 16 | Packet RAM byte address {page, offset} |
| mem_wdata | output | 8 | Packet RAM write data |
| curr_page | output | 8 | Hardware current-page pointer |
| bnd_page | output | 8 | Host boundary pointer |
| pkt_rcvd | output | 1 | One-cycle pulse when a frame is committed |
| ovw_flag | output | 1 | Sticky overwrite warning |

## Verification
The assertions check, on every cycle, the properties that hold at any instant: the stream stays closed until the ring is armed and while the header is being written, no write lands in the boundary page, the current page stays inside the ring, each commit pulse comes with a pointer move, and a rising overwrite flag leaves the pointer alone. What only the bench's scenarios can show is the exact byte placement: body offsets, page crossing and the wrap back to the ring start, header contents and their length and status fields, dropping of errored frames, and the two distinct overflow points, mid-frame and at the end. The bench shows these by comparing every RAM write, in order, against a pointer model.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int PAGE_W   = 8;
  localparam int OFF_W    = 8;
  localparam int ADDR_W   = PAGE_W + OFF_W;
  localparam int LEN_W    = 16;
  localparam int HDR_LEN  = 4;
  localparam int HIDX_W   = $clog2(HDR_LEN);
  localparam int ST_INTACT = 0;
  localparam int ST_GROUP  = 5;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_BODY = 2'd1,
    RS_DROP = 2'd2,
    RS_HDR  = 2'd3
  } rs_state_e;
endpackage

// File: rtl/rxring_step.sv
module rxring_step #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] page,
  input  logic [PW-1:0] first,
  input  logic [PW-1:0] limit,
  output logic [PW-1:0] nxt
);
  logic [PW:0] inc;
  always_comb begin
    inc = {1'b0, page} + {{PW{1'b0}}, 1'b1};
    if (inc >= {1'b0, limit}) nxt = first;
    else                      nxt = inc[PW-1:0];
  end
endmodule

// File: rtl/rxring_cnt.sv
module rxring_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= {{(W-1){1'b0}}, 1'b1};
    else if (inc)  cnt <= cnt + {{(W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/rxring_hdr.sv
module rxring_hdr
  import rxring_pkg::*;
#(
  parameter int PW = PAGE_W
) (
  input  logic [HIDX_W-1:0] idx,
  input  logic [7:0]        status,
  input  logic [PW-1:0]     next_pg,
  input  logic [LEN_W-1:0]  len,
  output logic [7:0]        hbyte
);
  localparam int NLEN = LEN_W / 8;
  logic [7:0] fields [HDR_LEN];

  assign fields[0] = status;
  assign fields[1] = 8'(next_pg);
  for (genvar g = 0; g < NLEN; g++) begin : g_len
    assign fields[2+g] = len[8*g +: 8];
  end

  assign hbyte = fields[idx];
endmodule

// File: rtl/rxring_mgr.sv
module rxring_mgr
  import rxring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_init,
  input  logic [PAGE_W-1:0] pg_start,
  input  logic [PAGE_W-1:0] pg_stop,
  input  logic              bnd_we,
  input  logic [PAGE_W-1:0] bnd_wdata,
  input  logic              ovw_clr,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_err,
  input  logic              rx_bcast,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [PAGE_W-1:0] curr_page,
  output logic [PAGE_W-1:0] bnd_page,
  output logic              pkt_rcvd,
  output logic              ovw_flag
);
  rs_state_e         state;
  logic              armed;
  logic [PAGE_W-1:0] wr_pg, eff_pg, step_pg, nxt_q;
  logic [OFF_W-1:0]  wr_off, eff_off;
  logic [7:0]        stat_q, stat_n, hbyte;
  logic [HIDX_W-1:0] hidx;
  logic [LEN_W-1:0]  flen;
  logic              acc, in_body, hdr_phase, off_end;

  assign in_body   = (state == RS_BODY);
  assign hdr_phase = (state == RS_HDR);
  assign rx_ready  = armed && !hdr_phase;
  assign acc       = rx_valid && rx_ready;
  assign eff_pg    = in_body ? wr_pg  : curr_page;
  assign eff_off   = in_body ? wr_off : OFF_W'(HDR_LEN);
  assign off_end   = (eff_off == {OFF_W{1'b1}});

  always_comb begin
    stat_n            = '0;
    stat_n[ST_INTACT] = 1'b1;
    stat_n[ST_GROUP]  = rx_bcast;
  end

  rxring_step #(.PW(PAGE_W)) u_step (
    .page (eff_pg),
    .first(pg_start),
    .limit(pg_stop),
    .nxt  (step_pg)
  );

  rxring_cnt #(.W(LEN_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .load (acc && (state == RS_IDLE)),
    .inc  (acc && in_body),
    .cnt  (flen)
  );

  rxring_hdr #(.PW(PAGE_W)) u_hdr (
    .idx    (hidx),
    .status (stat_q),
    .next_pg(nxt_q),
    .len    (flen),
    .hbyte  (hbyte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RS_IDLE;
      armed     <= 1'b0;
      wr_pg     <= '0;
      wr_off    <= '0;
      nxt_q     <= '0;
      stat_q    <= '0;
      hidx      <= '0;
      curr_page <= '0;
      bnd_page  <= '0;
      ovw_flag  <= 1'b0;
      pkt_rcvd  <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      pkt_rcvd <= 1'b0;
      mem_we   <= 1'b0;
      if (ring_init) begin
        armed     <= 1'b1;
        curr_page <= pg_start;
        bnd_page  <= pg_stop - PAGE_W'(1);
        ovw_flag  <= 1'b0;
        state     <= RS_IDLE;
        hidx      <= '0;
      end else begin
        if (bnd_we)  bnd_page <= bnd_wdata;
        if (ovw_clr) ovw_flag <= 1'b0;
        unique case (state)
          RS_IDLE, RS_BODY: begin
            if (acc) begin
              mem_we    <= 1'b1;
              mem_addr  <= {eff_pg, eff_off};
              mem_wdata <= rx_data;
              if (rx_last) begin
                if (rx_err) begin
                  state <= RS_IDLE;
                end else if (step_pg == bnd_page) begin
                  ovw_flag <= 1'b1;
                  state    <= RS_IDLE;
                end else begin
                  nxt_q  <= step_pg;
                  stat_q <= stat_n;
                  hidx   <= '0;
                  state  <= RS_HDR;
                end
              end else if (off_end) begin
                if (step_pg == bnd_page) begin
                  ovw_flag <= 1'b1;
                  state    <= RS_DROP;
                end else begin
                  wr_pg  <= step_pg;
                  wr_off <= '0;
                  state  <= RS_BODY;
                end
              end else begin
                wr_pg  <= eff_pg;
                wr_off <= eff_off + OFF_W'(1);
                state  <= RS_BODY;
              end
            end
          end
          RS_DROP: begin
            if (acc && rx_last) state <= RS_IDLE;
          end
          RS_HDR: begin
            mem_we    <= 1'b1;
            mem_addr  <= {curr_page, OFF_W'(hidx)};
            mem_wdata <= hbyte;
            hidx      <= hidx + HIDX_W'(1);
            if (hidx == HIDX_W'(HDR_LEN - 1)) begin
              curr_page <= nxt_q;
              pkt_rcvd  <= 1'b1;
              state     <= RS_IDLE;
            end
          end
          default: state <= RS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxring_mgr_chk.sv
module rxring_mgr_chk
  import rxring_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ring_init,
  input logic [PAGE_W-1:0] pg_start,
  input logic [PAGE_W-1:0] pg_stop,
  input logic              rx_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [PAGE_W-1:0] curr_page,
  input logic [PAGE_W-1:0] bnd_page,
  input logic              pkt_rcvd,
  input logic              ovw_flag,
  input logic              armed,
  input logic              hdr_phase
);
  // R1: stream closed before the ring is armed
  a_r1_closed_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!rx_ready && !mem_we));

  // R4: no byte taken while the header goes out
  a_r4_hold_in_header: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_phase |-> !rx_ready);

  // R7: every commit pulse moves the current page
  a_r7_pulse_moves_curr: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rcvd |-> (curr_page != $past(curr_page)));

  // R10: the boundary page is never written
  a_r10_no_write_on_bnd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[ADDR_W-1 -: PAGE_W] != bnd_page));

  // R11: an overwrite warning never comes with a pointer move
  a_r11_ovw_keeps_curr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovw_flag) |-> ($stable(curr_page) && !pkt_rcvd));

  // R13: current page stays inside the ring
  a_r13_curr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ring_init) |-> (curr_page >= pg_start && curr_page < pg_stop));
endmodule

bind rxring_mgr rxring_mgr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ring_init(ring_init),
  .pg_start (pg_start),
  .pg_stop  (pg_stop),
  .rx_ready (rx_ready),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .curr_page(curr_page),
  .bnd_page (bnd_page),
  .pkt_rcvd (pkt_rcvd),
  .ovw_flag (ovw_flag),
  .armed    (armed),
  .hdr_phase(hdr_phase)
);

// File: tb/rxring_mgr_bench.sv
module rxring_mgr_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ring_init = 1'b0;
  logic [7:0] pg_start = 8'h10;
  logic [7:0] pg_stop  = 8'h14;
  logic bnd_we = 1'b0;
  logic [7:0] bnd_wdata = 8'h00;
  logic ovw_clr = 1'b0;
  logic rx_valid = 1'b0;
  logic rx_ready;
  logic [7:0] rx_data = 8'h00;
  logic rx_last = 1'b0, rx_err = 1'b0, rx_bcast = 1'b0;
  logic mem_we;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] curr_page, bnd_page;
  logic pkt_rcvd, ovw_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxring_mgr u_rxring_mgr (
    .clk(clk), .rst_n(rst_n), .ring_init(ring_init),
    .pg_start(pg_start), .pg_stop(pg_stop),
    .bnd_we(bnd_we), .bnd_wdata(bnd_wdata), .ovw_clr(ovw_clr),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_last(rx_last), .rx_err(rx_err), .rx_bcast(rx_bcast),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .curr_page(curr_page), .bnd_page(bnd_page),
    .pkt_rcvd(pkt_rcvd), .ovw_flag(ovw_flag)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [23:0] exp_q [$];
  int m_pkts = 0;
  int seen_pkts = 0;
  logic [7:0] m_curr, m_bnd;
  bit m_ovw;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nx(input logic [7:0] p);
    return (p + 9'd1 >= {1'b0, pg_stop}) ? pg_start : p + 8'd1;
  endfunction

  // scoreboard monitor (R2 R3 R4 R5 R6 R7 R10)
  always @(negedge clk) begin
    if (rst_n && pkt_rcvd) seen_pkts++;
    if (rst_n && mem_we) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2/R10 unexpected write actual=%h:%h expected=none", mem_addr, mem_wdata);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        if ({mem_addr, mem_wdata} != e) begin
          n_bad++;
          $display("FAIL R2-R7 write actual=%h:%h expected=%h:%h",
                   mem_addr, mem_wdata, e[23:8], e[7:0]);
        end
      end
    end
  end

  task automatic send_frame(input int n, input bit err, input bit bc, input int seed);
    logic [7:0] c0, pg, d, nxt;
    int off;
    bit drop;
    c0 = m_curr; pg = m_curr; off = 4; drop = 0;
    for (int i = 0; i < n; i++) begin
      d = 8'(seed + i * 7);
      if (!drop) begin
        exp_q.push_back({pg, 8'(off), d});
        if (i == n - 1) begin
          nxt = nx(pg);
          if (!err) begin
            if (nxt == m_bnd) m_ovw = 1;
            else begin
              exp_q.push_back({c0, 8'd0, 8'h01 | (8'(bc) << 5)});
              exp_q.push_back({c0, 8'd1, nxt});
              exp_q.push_back({c0, 8'd2, 8'(n)});
              exp_q.push_back({c0, 8'd3, 8'(n >> 8)});
              m_curr = nxt;
              m_pkts++;
            end
          end
        end else if (off == 255) begin
          if (nx(pg) == m_bnd) begin m_ovw = 1; drop = 1; end
          else begin pg = nx(pg); off = 0; end
        end else off++;
      end
    end
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_data  = 8'(seed + i * 7);
      rx_last  = (i == n - 1);
      rx_err   = err && (i == n - 1);
      rx_bcast = bc;
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0; rx_bcast = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic host_bnd(input logic [7:0] v);
    bnd_wdata = v; bnd_we = 1'b1;
    @(negedge clk);
    bnd_we = 1'b0;
    m_bnd = v;
    @(negedge clk);
    check("R9 boundary load", bnd_page, v);
  endtask

  task automatic frame_checks(input string tag);
    check({tag, " curr"}, curr_page, m_curr);
    check({tag, " ovw"}, ovw_flag, m_ovw);
    check({tag, " pulses"}, seen_pkts, m_pkts);
    check({tag, " drained"}, exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, stream closed before init
    check("R1 ready before init", rx_ready, 0);
    check("R1 ovw at reset", ovw_flag, 0);
    check("R1 curr at reset", curr_page, 0);
    rx_valid = 1'b1; rx_data = 8'hAA;
    repeat (4) @(negedge clk);
    check("R1 still closed", rx_ready, 0);
    rx_valid = 1'b0;
    @(negedge clk);

    ring_init = 1'b1; @(negedge clk); ring_init = 1'b0;
    m_curr = 8'h10; m_bnd = 8'h13; m_ovw = 0;
    check("R1 init curr", curr_page, 8'h10);
    check("R1 init bnd", bnd_page, 8'h13);
    check("R1 armed", rx_ready, 1);

    // R2 R4 R5 R6 R7: short frame in one page
    send_frame(60, 0, 0, 3);
    frame_checks("R7 frame A");
    host_bnd(8'h10);

    // R3 R6: page crossing, group flag in status
    send_frame(300, 0, 1, 11);
    frame_checks("R3 frame B");

    // R8: errored frame discarded
    send_frame(80, 1, 0, 29);
    frame_checks("R8 errored frame");
    host_bnd(8'h12);

    // R3: wrap from last ring page to first
    send_frame(260, 0, 0, 41);
    frame_checks("R3 wrap frame D");

    // R10: overflow in mid-frame, rest ignored
    send_frame(600, 0, 0, 53);
    frame_checks("R10 mid overflow");
    check("R10 ovw set", ovw_flag, 1);

    // R12: flag stays until cleared
    repeat (3) @(negedge clk);
    check("R12 sticky", ovw_flag, 1);
    ovw_clr = 1'b1; @(negedge clk); ovw_clr = 1'b0; m_ovw = 0;
    check("R12 cleared", ovw_flag, 0);

    // R11: page after frame is the boundary
    send_frame(100, 0, 0, 67);
    frame_checks("R11 end overflow");
    check("R11 ovw set", ovw_flag, 1);

    // R9 R7: freed space lets the next frame commit
    host_bnd(8'h10);
    send_frame(40, 0, 1, 79);
    frame_checks("R7 recovery frame");

    // R1 R12 R13: re-init reloads pointers and clears flag
    ring_init = 1'b1; @(negedge clk); ring_init = 1'b0;
    check("R13 reinit curr", curr_page, 8'h10);
    check("R1 reinit bnd", bnd_page, 8'h13);
    check("R12 reinit ovw", ovw_flag, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule